// File: doc/BRIEF.md
# Role-Mapped CPU Register File

This block holds the eight working registers of a small 8-bit processor. Each register is picked by a 3-bit index, and five indices carry fixed duties: index 0 is the status register, index 1 receives the arithmetic unit's result, indices 2 and 3 supply the arithmetic unit's first and second operands, and index 4 names the I/O port a port transfer uses. Indices 5 to 7 are plain storage. Two indexed read ports and one indexed write port serve ordinary register moves. A dedicated result port loads index 1, and a dedicated status port loads index 0. A clear command zeroes index 0. The operand registers and the port register are also driven straight out of the block, so the arithmetic unit and the I/O logic need no read port.

The status register keeps its five flags in fixed bits, and the block does not interpret them: zero in bit 0, carry in bit 1, even parity in bit 2, equality in bit 3 and greater-than in bit 4. Bits 5 to 7 have no assigned meaning, but they are stored, written and cleared like the other bits. Each register also has two sticky activity bits, one for reads and one for writes. Debug logic can use these to see which registers an instruction touched. A single strobe clears all of them.

The reset input is asserted asynchronously. Its release is synchronised inside the block, so the block leaves reset on the second rising clock edge after the input goes high.

Top module: `cpu_role_regfile`

## Requirements
- R1: While reset is active, and after it, every register reads 0x00 and every activity bit is 0.
- R2: A general write (wr_en) of wr_data to wr_addr is visible on both read ports from the next cycle on, and this includes indices 0 and 1. Reads are combinational. A read of the written index in the same cycle still returns the old value.
- R3: alu_we loads alu_data into index 1 whatever it held before. If a general write targets index 1 in the same cycle, alu_we wins.
- R4: flg_we loads flg_data into index 0. If a general write targets index 0 in the same cycle, flg_we wins.
- R5: flg_clr sets all eight bits of index 0 to zero, and it wins over both flg_we and a general write in the same cycle.
- R6: alu_opnd_a always equals index 2, alu_opnd_b always equals index 3, and port_sel always equals index 4.
- R7: Bit i of was_read is set after a cycle in which rd0_en or rd1_en is high with its address equal to i. It stays set until it is cleared. A read address whose enable is low does not set it.
- R8: Bit i of was_written is set after any cycle in which register i is the target of a general write, a result write (i = 1), a status write or a status clear (i = 0). This happens even if another path wins the write. The bit stays set until it is cleared.
- R9: mark_clr clears every activity bit on the next edge. An access in the same cycle as mark_clr still sets its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| rd0_en | input | 1 | Read port 0 access marker enable |
| rd0_addr | input | 3 | Read port 0 index |
| rd0_data | output | 8 | Read port 0 data (combinational) |
| rd1_en | input | 1 | Read port 1 access marker enable |
| rd1_addr | input | 3 | Read port 1 index |
| rd1_data | output | 8 | Read port 1 data (combinational) |
| wr_en | input | 1 | General write strobe |
| wr_addr | input | 3 | General write index |
| wr_data | input | 8 | General write data |
| alu_we | input | 1 | Result write strobe for index 1 |
| alu_data | input | 8 | Arithmetic result |
| flg_we | input | 1 | Status write strobe for index 0 |
| flg_data | input | 8 | New status value |
| flg_clr | input | 1 | Zero index 0 |
| mark_clr | input | 1 | Clear all activity bits |
| alu_opnd_a | output | 8 | Contents of index 2 |
| alu_opnd_b | output | 8 | Contents of index 3 |
| port_sel | output | 8 | Contents of index 4 |
| was_read | output | 8 | Sticky read-activity bit per index |
| was_written | output | 8 | Sticky write-activity bit per index |

## Verification
A wrong value in a storage cell shows up on any read port that addresses it. It appears in the same cycle because reads are combinational. For indices 2 to 4 it also shows at once on the direct operand and port outputs. A wrong priority among the three write paths into index 0 or 1 leaves a wrong value that the next read of that index exposes. An activity bit that is set wrongly or lost stays visible on was_read or was_written from the edge that updated it until the next clear.

// File: rtl/crf_pkg.sv
package crf_pkg;

  // Fixed duty of each index. The write arbitration depends on these.
  localparam int unsigned ROLE_FLAGS    = 0;
  localparam int unsigned ROLE_ALU_OUT  = 1;
  localparam int unsigned ROLE_OPND_A   = 2;
  localparam int unsigned ROLE_OPND_B   = 3;
  localparam int unsigned ROLE_PORT_SEL = 4;

  // Winning write source of a cell in one cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_GEN  = 2'd1,
    SRC_DED  = 2'd2,
    SRC_CLR  = 2'd3
  } wr_src_e;

endpackage

// File: rtl/crf_rst_sync.sv
module crf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/crf_rd_port.sv
module crf_rd_port #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned NUM_REGS = 1 << ADDR_W
) (
  input  logic                               en,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]    regs,
  output logic [DATA_W-1:0]                  data,
  output logic [NUM_REGS-1:0]                hit
);

  assign data = regs[addr];

  always_comb begin
    hit = '0;
    for (int unsigned k = 0; k < NUM_REGS; k++) begin
      if (en && (addr == ADDR_W'(k))) begin
        hit[k] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/crf_cell.sv
module crf_cell
  import crf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_hit,
  input  logic [DATA_W-1:0] gen_data,
  input  logic              ded_we,
  input  logic [DATA_W-1:0] ded_data,
  input  logic              clr,
  input  logic              rd_hit,
  input  logic              mark_clr,
  output logic [DATA_W-1:0] q,
  output logic              was_rd,
  output logic              was_wr
);

  wr_src_e           src;
  logic              q_en;
  logic [DATA_W-1:0] q_nxt;
  logic              touched;
  logic              rd_nxt;
  logic              wr_nxt;

  // Priority: clear, then dedicated port, then general write
  always_comb begin
    if (clr) begin
      src = SRC_CLR;
    end else if (ded_we) begin
      src = SRC_DED;
    end else if (gen_hit) begin
      src = SRC_GEN;
    end else begin
      src = SRC_NONE;
    end
  end

  always_comb begin
    case (src)
      SRC_CLR: q_nxt = '0;
      SRC_DED: q_nxt = ded_data;
      SRC_GEN: q_nxt = gen_data;
      default: q_nxt = q;
    endcase
  end

  assign q_en    = (src != SRC_NONE);
  assign touched = gen_hit | ded_we | clr;
  assign rd_nxt  = (was_rd & ~mark_clr) | rd_hit;
  assign wr_nxt  = (was_wr & ~mark_clr) | touched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_rd <= 1'b0;
      was_wr <= 1'b0;
    end else begin
      was_rd <= rd_nxt;
      was_wr <= wr_nxt;
    end
  end

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

  // R4
  ded_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ded_we && !clr) |=> (q == $past(ded_data)));

  // R7
  rd_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> was_rd);

  // R8
  wr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (was_wr && !mark_clr) |=> was_wr);

  // R9
  mark_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_clr && !rd_hit) |=> !was_rd);

endmodule

// File: rtl/cpu_role_regfile.sv
module cpu_role_regfile
  import crf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned NUM_REGS = 1 << ADDR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd0_en,
  input  logic [ADDR_W-1:0]   rd0_addr,
  output logic [DATA_W-1:0]   rd0_data,
  input  logic                rd1_en,
  input  logic [ADDR_W-1:0]   rd1_addr,
  output logic [DATA_W-1:0]   rd1_data,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                alu_we,
  input  logic [DATA_W-1:0]   alu_data,
  input  logic                flg_we,
  input  logic [DATA_W-1:0]   flg_data,
  input  logic                flg_clr,
  input  logic                mark_clr,
  output logic [DATA_W-1:0]   alu_opnd_a,
  output logic [DATA_W-1:0]   alu_opnd_b,
  output logic [DATA_W-1:0]   port_sel,
  output logic [NUM_REGS-1:0] was_read,
  output logic [NUM_REGS-1:0] was_written
);

  logic                            rst_sync_n;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [NUM_REGS-1:0]             rd0_hit;
  logic [NUM_REGS-1:0]             rd1_hit;
  logic [NUM_REGS-1:0]             rd_hit_any;

  crf_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  crf_rd_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd0 (
    .en   (rd0_en),
    .addr (rd0_addr),
    .regs (regs_q),
    .data (rd0_data),
    .hit  (rd0_hit)
  );

  crf_rd_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd1 (
    .en   (rd1_en),
    .addr (rd1_addr),
    .regs (regs_q),
    .data (rd1_data),
    .hit  (rd1_hit)
  );

  assign rd_hit_any = rd0_hit | rd1_hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
    logic              ded_we_i;
    logic [DATA_W-1:0] ded_data_i;
    logic              clr_i;
    logic              gen_hit_i;

    if (i == ROLE_FLAGS) begin : g_flags
      assign ded_we_i   = flg_we;
      assign ded_data_i = flg_data;
      assign clr_i      = flg_clr;
    end else if (i == ROLE_ALU_OUT) begin : g_result
      assign ded_we_i   = alu_we;
      assign ded_data_i = alu_data;
      assign clr_i      = 1'b0;
    end else begin : g_plain
      assign ded_we_i   = 1'b0;
      assign ded_data_i = '0;
      assign clr_i      = 1'b0;
    end

    assign gen_hit_i = wr_en && (wr_addr == ADDR_W'(i));

    crf_cell #(.DATA_W(DATA_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .gen_hit  (gen_hit_i),
      .gen_data (wr_data),
      .ded_we   (ded_we_i),
      .ded_data (ded_data_i),
      .clr      (clr_i),
      .rd_hit   (rd_hit_any[i]),
      .mark_clr (mark_clr),
      .q        (regs_q[i]),
      .was_rd   (was_read[i]),
      .was_wr   (was_written[i])
    );
  end

  assign alu_opnd_a = regs_q[ROLE_OPND_A];
  assign alu_opnd_b = regs_q[ROLE_OPND_B];
  assign port_sel   = regs_q[ROLE_PORT_SEL];

  // R2
  gen_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en
     && !((wr_addr == ADDR_W'(ROLE_FLAGS)) && (flg_we || flg_clr))
     && !((wr_addr == ADDR_W'(ROLE_ALU_OUT)) && alu_we))
    |=> (regs_q[$past(wr_addr)] == $past(wr_data)));

  // R3
  alu_result_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    alu_we |=> (rd0_addr != ADDR_W'(ROLE_ALU_OUT)) || (rd0_data == $past(alu_data)));

  // R5
  flag_clear_port_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flg_clr && flg_we) |=> (regs_q[ROLE_FLAGS] == '0));

  // R8
  wr_mark_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |=> was_written[$past(wr_addr)]);

endmodule

// File: tb/test_cpu_role_regfile.sv
`timescale 1ns/1ps
module test_cpu_role_regfile;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd0_en, rd1_en, wr_en, alu_we, flg_we, flg_clr, mark_clr;
  logic [2:0] rd0_addr, rd1_addr, wr_addr;
  logic [7:0] wr_data, alu_data, flg_data;
  logic [7:0] rd0_data, rd1_data, alu_opnd_a, alu_opnd_b, port_sel;
  logic [7:0] was_read, was_written;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] m_reg [8];
  logic [7:0] m_rd;
  logic [7:0] m_wr;

  always #2.5 clk = ~clk;

  cpu_role_regfile i_cpu_role_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_en(rd1_en), .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .alu_we(alu_we), .alu_data(alu_data),
    .flg_we(flg_we), .flg_data(flg_data), .flg_clr(flg_clr),
    .mark_clr(mark_clr),
    .alu_opnd_a(alu_opnd_a), .alu_opnd_b(alu_opnd_b), .port_sel(port_sel),
    .was_read(was_read), .was_written(was_written)
  );

  // {wr_en, alu_we, flg_we, flg_clr, wr_addr[2:0], data[7:0], rd0_addr[2:0]}
  // result data = data ^ 5A, status data = data ^ A5
  localparam int NVEC = 14;
  localparam logic [17:0] VEC [NVEC] = '{
    {4'b1000, 3'd2, 8'h11, 3'd2},
    {4'b1000, 3'd3, 8'h22, 3'd3},
    {4'b1000, 3'd4, 8'h5A, 3'd2},
    {4'b1000, 3'd7, 8'hC3, 3'd4},
    {4'b0100, 3'd0, 8'h99, 3'd1},
    {4'b1100, 3'd1, 8'h44, 3'd1},
    {4'b0010, 3'd0, 8'h1F, 3'd0},
    {4'b1010, 3'd0, 8'h08, 3'd0},
    {4'b1011, 3'd0, 8'h77, 3'd0},
    {4'b1000, 3'd0, 8'hFF, 3'd0},
    {4'b1000, 3'd1, 8'h3C, 3'd5},
    {4'b0001, 3'd0, 8'h00, 3'd0},
    {4'b1000, 3'd5, 8'h66, 3'd7},
    {4'b1100, 3'd6, 8'h01, 3'd6}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rd0_en = 0; rd1_en = 0; wr_en = 0; alu_we = 0; flg_we = 0;
    flg_clr = 0; mark_clr = 0;
  endtask

  task automatic model_reset();
    for (int k = 0; k < 8; k++) m_reg[k] = 8'h00;
    m_rd = 8'h00;
    m_wr = 8'h00;
  endtask

  // Inputs are set at a falling edge; checks before and after the next rise.
  task automatic tick(input string tag);
    logic [7:0] nr [8];
    logic [7:0] nrd, nwr;
    #1;
    chk({tag, " R2 rd0 pre-edge"}, rd0_data, m_reg[rd0_addr]);
    chk({tag, " R2 rd1 pre-edge"}, rd1_data, m_reg[rd1_addr]);
    chk("R6 alu_opnd_a", alu_opnd_a, m_reg[2]);
    chk("R6 alu_opnd_b", alu_opnd_b, m_reg[3]);
    chk("R6 port_sel",   port_sel,   m_reg[4]);
    nr  = m_reg;
    nrd = mark_clr ? 8'h00 : m_rd;
    nwr = mark_clr ? 8'h00 : m_wr;
    if (wr_en)   begin nr[wr_addr] = wr_data;  nwr[wr_addr] = 1'b1; end
    if (alu_we)  begin nr[1] = alu_data;       nwr[1] = 1'b1; end
    if (flg_we)  begin nr[0] = flg_data;       nwr[0] = 1'b1; end
    if (flg_clr) begin nr[0] = 8'h00;          nwr[0] = 1'b1; end
    if (rd0_en)  nrd[rd0_addr] = 1'b1;
    if (rd1_en)  nrd[rd1_addr] = 1'b1;
    @(posedge clk);
    m_reg = nr;
    m_rd  = nrd;
    m_wr  = nwr;
    @(negedge clk);
    chk({tag, " R7 was_read"},    was_read,    m_rd);
    chk({tag, " R8 was_written"}, was_written, m_wr);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle();
    #1;
    model_reset();
    chk("R1 was_read in reset", was_read, 8'h00);
    chk("R1 was_written in reset", was_written, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rd0_addr = 0; rd1_addr = 0; wr_addr = 0;
    wr_data = 0; alu_data = 0; flg_data = 0;
    do_reset();

    // R1: every index reads zero, enables low so no markers
    for (int k = 0; k < 8; k++) begin
      rd0_addr = 3'(k);
      rd1_addr = 3'(7 - k);
      #1;
      chk("R1 reset rd0", rd0_data, 8'h00);
      chk("R1 reset rd1", rd1_data, 8'h00);
    end
    chk("R1 reset was_read", was_read, 8'h00);
    chk("R1 reset was_written", was_written, 8'h00);

    // Vector walk
    for (int v = 0; v < NVEC; v++) begin
      logic [17:0] e;
      string tg;
      int tgt;
      e = VEC[v];
      idle();
      wr_en    = e[17];
      alu_we   = e[16];
      flg_we   = e[15];
      flg_clr  = e[14];
      wr_addr  = e[13:11];
      wr_data  = e[10:3];
      alu_data = e[10:3] ^ 8'h5A;
      flg_data = e[10:3] ^ 8'hA5;
      rd0_en   = 1'b1;
      rd0_addr = e[2:0];
      rd1_en   = 1'b1;
      rd1_addr = e[13:11];
      if (e[14])      begin tg = "R5"; tgt = 0; end
      else if (e[15]) begin tg = "R4"; tgt = 0; end
      else if (e[16]) begin tg = "R3"; tgt = 1; end
      else            begin tg = "R2"; tgt = int'(e[13:11]); end
      tick(tg);
      idle();
      rd1_addr = 3'(tgt);
      #1;
      chk({tg, " post-write value"}, rd1_data, m_reg[tgt]);
    end

    // R9: clear alone
    idle();
    mark_clr = 1'b1;
    tick("R9 clear");
    chk("R9 was_read cleared", was_read, 8'h00);
    chk("R9 was_written cleared", was_written, 8'h00);

    // R7: address without enable sets nothing
    idle();
    rd0_addr = 3'd5;
    rd1_addr = 3'd6;
    tick("R7 no enable");
    chk("R7 no-enable was_read", was_read, 8'h00);

    // R7: enabled read sets its bit
    idle();
    rd1_en = 1'b1;
    rd1_addr = 3'd6;
    tick("R7 enable");
    chk("R7 enabled was_read", was_read, 8'h40);

    // R9: access in the clear cycle survives
    idle();
    mark_clr = 1'b1;
    rd0_en = 1'b1;
    rd0_addr = 3'd3;
    wr_en = 1'b1;
    wr_addr = 3'd7;
    wr_data = 8'hE7;
    tick("R9 same-cycle");
    chk("R9 same-cycle was_read", was_read, 8'h08);
    chk("R9 same-cycle was_written", was_written, 8'h80);

    // R8: overridden general write still marks; status clear marks index 0
    idle();
    mark_clr = 1'b1;
    tick("R8 prep");
    idle();
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h12;
    alu_we = 1'b1; alu_data = 8'h34;
    tick("R8 override");
    idle();
    flg_clr = 1'b1;
    tick("R8 clear marks");
    chk("R8 written bits", was_written, 8'h03);

    // R1: reset in mid-run
    idle();
    rd0_addr = 3'd1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset rd0", rd0_data, 8'h00);
    chk("R1 mid reset port_sel", port_sel, 8'h00);
    chk("R1 mid reset was_written", was_written, 8'h00);
    do_reset();
    chk("R1 after reset was_read", was_read, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule